// File: doc/BRIEF.md
# Correlator Time Base and Interrupt Generator

This block keeps time for a bank of correlator channels. Running on the sample clock, it holds two programmable down counters. The measurement counter emits a periodic one-cycle strobe that every channel uses to latch its measurements on the same edge. The accumulator counter marks when accumulation results are ready to be collected. Each counter's event sets a sticky flag in a status word. The flags stay set until software clears them. The accumulator flag, gated by an enable input, drives a level interrupt line.

A flat register bus reaches every register. The bus carries a byte offset, and the read data is combinational from the offset. Software can:
- program either divide value,
- read either counter live,
- clear status flags one by one,
- hold the whole time base in a software reset.

The block also keeps a per-channel bitmap of channels that have dumped fresh accumulator data. Reading the bitmap clears it.

Top module: `corr_time_base`

## Requirements
- R1: After the measurement divide D (written at offset 0x3c4) is loaded, `ticStrobe` is high exactly in the cycles where the time since the load, modulo D+1, equals D. When D is 0, the strobe is high in every cycle.
- R2: The accumulator counter uses the same period rule with its own divide (offset 0x3c8). After reset the divides read back 0x18FFFF and 0x1FFF.
- R3: STATUS (offset 0x380) has the measurement flag in bit 0 and the accumulator flag in bit 1. Each flag is set in the cycle after its counter reaches zero, and it stays set until it is cleared.
- R4: A write to offset 0x390 clears STATUS bit 0 when data bit 0 is 1, and clears STATUS bit 1 when data bit 1 is 1. Other flags are not affected. If a counter event falls on the same edge as the clear, the event wins.
- R5: `accumIrq` is high only when the accumulator flag is set and `irqEnable` is high. It goes low once the flag is cleared.
- R6: The measurement count (offset 0x388) and the accumulator count (offset 0x38c) read live. Each count falls by one per cycle and reloads its divide after zero. Writing a divide makes the count equal to the written value in the next cycle.
- R7: NEW_DATA (offset 0x384) bit i is set by a pulse on `dumpIn[i]`. A read with `busRe` returns the bitmap and then clears it. A dump that arrives on the same edge as the clear survives.
- R8: Writing 1 to bit 0 at offset 0x3c0 holds both counts at their divides and suppresses both events. It also clears STATUS and NEW_DATA. The register reads back 1. Writing 0 releases the hold, and the first strobe then comes D cycles later.
- R9: When the divide is above zero, `ticStrobe` is exactly one cycle wide.
- R10: After reset, STATUS, NEW_DATA and `accumIrq` are 0, and the counts read their default divides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWe | input | 1 | Register write strobe |
| busRe | input | 1 | Register read strobe (clears NEW_DATA when it addresses it) |
| busAddr | input | 10 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data |
| dumpIn | input | NUM_CH | One-cycle dump pulse per channel |
| irqEnable | input | 1 | Accumulator interrupt enable |
| ticStrobe | output | 1 | Shared measurement strobe |
| accumIrq | output | 1 | Level accumulator interrupt |

## Verification
Both counters are swept over every divide from 0 to 7. The bench compares each cycle's strobe and live count with arithmetic on the time since the load, which separates errors in the period, the phase after a load, and the reload. The flag tests run each clear bit alone and then a clear that falls on a counter event, which separates clearing the wrong flag from losing an event. A walking one over the dump inputs, together with a dump that falls on the same edge as a clearing read, tells bit-mapping errors apart from errors in clear priority. The software-reset pattern checks that the hold is complete and that the phase on release is correct.

// File: rtl/corr_tb_pkg.sv
package corr_tb_pkg;
  localparam int ADDR_W = 10;
  localparam logic [ADDR_W-1:0] ADR_STATUS  = 10'h380;
  localparam logic [ADDR_W-1:0] ADR_NEWDATA = 10'h384;
  localparam logic [ADDR_W-1:0] ADR_TICCNT  = 10'h388;
  localparam logic [ADDR_W-1:0] ADR_ACCCNT  = 10'h38c;
  localparam logic [ADDR_W-1:0] ADR_CLEAR   = 10'h390;
  localparam logic [ADDR_W-1:0] ADR_SWRST   = 10'h3c0;
  localparam logic [ADDR_W-1:0] ADR_TICDIV  = 10'h3c4;
  localparam logic [ADDR_W-1:0] ADR_ACCDIV  = 10'h3c8;

  typedef struct packed {
    logic wrTicDiv;
    logic wrAccDiv;
    logic wrClear;
    logic wrReset;
    logic rdNewData;
  } tbStrobe_t;
endpackage

// File: rtl/corr_div_counter.sv
module corr_div_counter #(
  parameter int CNT_W = 24,
  parameter logic [CNT_W-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hold,
  input  logic             load,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] divide,
  output logic             pulse
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divide <= INIT;
      count  <= INIT;
    end else if (load) begin
      divide <= loadVal;
      count  <= loadVal;
    end else if (hold || count == '0) begin
      count <= divide;
    end else begin
      count <= count - CNT_W'(1);
    end
  end

  assign pulse = (count == '0) && !hold;

  // R6: a free-running count falls by exactly one
  a_r6_decrement: assert property (@(posedge clk) disable iff (!rstN)
    (!load && !hold && count != '0) |=> count == $past(count) - CNT_W'(1));
  // R1: terminal count reloads the divide
  a_r1_reload: assert property (@(posedge clk) disable iff (!rstN)
    (!load && count == '0) |=> count == divide);
  // R9: pulse lasts one cycle when the divide is nonzero
  a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (pulse && divide != '0 && !load) |=> !pulse);
endmodule

// File: rtl/corr_tb_ctrl.sv
module corr_tb_ctrl
  import corr_tb_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int NUM_CH = 12,
  parameter int DATA_W = 32
) (
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  ticCount,
  input  logic [CNT_W-1:0]  accCount,
  input  logic [CNT_W-1:0]  ticDiv,
  input  logic [CNT_W-1:0]  accDiv,
  input  logic              ticFlag,
  input  logic              accFlag,
  input  logic [NUM_CH-1:0] newData,
  input  logic              swRst,
  output tbStrobe_t         strb,
  output logic [DATA_W-1:0] busRdata
);
  always_comb begin
    strb.wrTicDiv  = busWe && busAddr == ADR_TICDIV;
    strb.wrAccDiv  = busWe && busAddr == ADR_ACCDIV;
    strb.wrClear   = busWe && busAddr == ADR_CLEAR;
    strb.wrReset   = busWe && busAddr == ADR_SWRST;
    strb.rdNewData = busRe && busAddr == ADR_NEWDATA;
  end

  always_comb begin
    case (busAddr)
      ADR_STATUS:  busRdata = DATA_W'({accFlag, ticFlag});
      ADR_NEWDATA: busRdata = DATA_W'(newData);
      ADR_TICCNT:  busRdata = DATA_W'(ticCount);
      ADR_ACCCNT:  busRdata = DATA_W'(accCount);
      ADR_SWRST:   busRdata = DATA_W'(swRst);
      ADR_TICDIV:  busRdata = DATA_W'(ticDiv);
      ADR_ACCDIV:  busRdata = DATA_W'(accDiv);
      default:     busRdata = '0;
    endcase
  end
endmodule

// File: rtl/corr_tb_dpath.sv
module corr_tb_dpath
  import corr_tb_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int NUM_CH = 12,
  parameter int DATA_W = 32,
  parameter logic [CNT_W-1:0] TIC_INIT = 24'h18FFFF,
  parameter logic [CNT_W-1:0] ACC_INIT = 24'h001FFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  tbStrobe_t         strb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_CH-1:0] dumpIn,
  output logic [CNT_W-1:0]  ticCount,
  output logic [CNT_W-1:0]  accCount,
  output logic [CNT_W-1:0]  ticDiv,
  output logic [CNT_W-1:0]  accDiv,
  output logic              ticPulse,
  output logic              accPulse,
  output logic              ticFlag,
  output logic              accFlag,
  output logic [NUM_CH-1:0] newData,
  output logic              swRst
);
  localparam int NUM_CNT = 2;
  localparam logic [NUM_CNT-1:0][CNT_W-1:0] INITS = {ACC_INIT, TIC_INIT};

  logic [NUM_CNT-1:0]            loads;
  logic [NUM_CNT-1:0][CNT_W-1:0] counts;
  logic [NUM_CNT-1:0][CNT_W-1:0] divs;
  logic [NUM_CNT-1:0]            pulses;

  assign loads = {strb.wrAccDiv, strb.wrTicDiv};

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    corr_div_counter #(.CNT_W(CNT_W), .INIT(INITS[g])) u_cnt (
      .clk(clk), .rstN(rstN), .hold(swRst), .load(loads[g]),
      .loadVal(wdata[CNT_W-1:0]), .count(counts[g]),
      .divide(divs[g]), .pulse(pulses[g]));
  end

  assign ticCount = counts[0];
  assign accCount = counts[1];
  assign ticDiv   = divs[0];
  assign accDiv   = divs[1];
  assign ticPulse = pulses[0];
  assign accPulse = pulses[1];

  logic clrTic, clrAcc;
  assign clrTic = strb.wrClear && wdata[0];
  assign clrAcc = strb.wrClear && wdata[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swRst   <= 1'b0;
      ticFlag <= 1'b0;
      accFlag <= 1'b0;
      newData <= '0;
    end else begin
      if (strb.wrReset) swRst <= wdata[0];
      if (swRst) begin
        ticFlag <= 1'b0;
        accFlag <= 1'b0;
        newData <= '0;
      end else begin
        ticFlag <= ticPulse || (ticFlag && !clrTic);
        accFlag <= accPulse || (accFlag && !clrAcc);
        newData <= dumpIn | (strb.rdNewData ? '0 : newData);
      end
    end
  end

  // R3: a set flag survives any cycle without its clear
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ticFlag && !clrTic && !swRst) |=> ticFlag);
  // R4: a clear with no coincident event drops the flag
  a_r4_clear: assert property (@(posedge clk) disable iff (!rstN)
    (clrAcc && !accPulse) |=> !accFlag);
  // R7: a dump always lands in the bitmap
  a_r7_dump_sets: assert property (@(posedge clk) disable iff (!rstN)
    (!swRst && dumpIn != '0) |=> ((newData & $past(dumpIn)) == $past(dumpIn)));
  // R8: the hold keeps both events silent
  a_r8_hold_quiet: assert property (@(posedge clk) disable iff (!rstN)
    swRst |-> (!ticPulse && !accPulse));
endmodule

// File: rtl/corr_time_base.sv
module corr_time_base
  import corr_tb_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int NUM_CH = 12,
  parameter int DATA_W = 32,
  parameter logic [CNT_W-1:0] TIC_INIT = 24'h18FFFF,
  parameter logic [CNT_W-1:0] ACC_INIT = 24'h001FFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [NUM_CH-1:0] dumpIn,
  input  logic              irqEnable,
  output logic              ticStrobe,
  output logic              accumIrq
);
  tbStrobe_t         strb;
  logic [CNT_W-1:0]  ticCount, accCount, ticDiv, accDiv;
  logic              ticPulse, accPulse, ticFlag, accFlag, swRst;
  logic [NUM_CH-1:0] newData;

  corr_tb_ctrl #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_ctrl (
    .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .ticCount(ticCount), .accCount(accCount), .ticDiv(ticDiv), .accDiv(accDiv),
    .ticFlag(ticFlag), .accFlag(accFlag), .newData(newData), .swRst(swRst),
    .strb(strb), .busRdata(busRdata));

  corr_tb_dpath #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .DATA_W(DATA_W),
                  .TIC_INIT(TIC_INIT), .ACC_INIT(ACC_INIT)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(busWdata), .dumpIn(dumpIn),
    .ticCount(ticCount), .accCount(accCount), .ticDiv(ticDiv), .accDiv(accDiv),
    .ticPulse(ticPulse), .accPulse(accPulse), .ticFlag(ticFlag),
    .accFlag(accFlag), .newData(newData), .swRst(swRst));

  assign ticStrobe = ticPulse;
  assign accumIrq  = accFlag && irqEnable;

  // R5: interrupt falls once a clear takes the flag down
  a_r5_irq_drop: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADR_CLEAR && busWdata[1] && !accPulse) |=> !accumIrq);
endmodule

// File: tb/corr_time_base_tb.sv
module corr_time_base_tb;
  import corr_tb_pkg::*;
  localparam int NUM_CH = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWe = 1'b0, busRe = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [NUM_CH-1:0] dumpIn = '0;
  logic irqEnable = 1'b0;
  logic ticStrobe, accumIrq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  corr_time_base u_dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .dumpIn(dumpIn),
    .irqEnable(irqEnable), .ticStrobe(ticStrobe), .accumIrq(accumIrq));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic wrReg(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rdNew(output logic [31:0] d);
    busAddr = ADR_NEWDATA; busRe = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRe = 1'b0;
  endtask

  task automatic dump(input logic [NUM_CH-1:0] v);
    dumpIn = v;
    @(negedge clk);
    dumpIn = '0;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    int mism;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R10 / R2 reset state
    peek(ADR_STATUS, d);  chk(d == 0, "R10 status", d, 0);
    peek(ADR_NEWDATA, d); chk(d == 0, "R10 newdata", d, 0);
    chk(accumIrq == 0, "R10 irq", accumIrq, 0);
    peek(ADR_TICCNT, d);  chk(d == 32'h18FFFF, "R10 tic count", d, 32'h18FFFF);
    peek(ADR_TICDIV, d);  chk(d == 32'h18FFFF, "R2 tic divide default", d, 32'h18FFFF);
    peek(ADR_ACCDIV, d);  chk(d == 32'h1FFF, "R2 acc divide default", d, 32'h1FFF);

    // R1 R6 R9 measurement sweep
    for (int dv = 0; dv < 8; dv++) begin
      wrReg(ADR_TICDIV, dv);
      mism = 0;
      for (int t = 0; t < 4 * (dv + 1); t++) begin
        peek(ADR_TICCNT, d);
        if (ticStrobe !== ((t % (dv + 1)) == dv)) mism++;
        if (d != 32'(dv - (t % (dv + 1)))) mism++;
        @(negedge clk);
      end
      chk(mism == 0, "R1 R6 R9 tic sweep", mism, 0);
    end

    // R2 R6 accumulator sweep
    for (int dv = 0; dv < 8; dv++) begin
      wrReg(ADR_ACCDIV, dv);
      mism = 0;
      for (int t = 0; t < 3 * (dv + 1); t++) begin
        peek(ADR_ACCCNT, d);
        if (d != 32'(dv - (t % (dv + 1)))) mism++;
        @(negedge clk);
      end
      chk(mism == 0, "R2 R6 acc sweep", mism, 0);
    end

    // R3 R5 flag timing
    irqEnable = 1'b1;
    wrReg(ADR_TICDIV, 5000);
    wrReg(ADR_ACCDIV, 1000);
    wrReg(ADR_CLEAR, 3);
    peek(ADR_STATUS, d); chk(d == 0, "R4 clear both", d, 0);
    wrReg(ADR_ACCDIV, 4);
    mism = 0;
    for (int t = 0; t <= 5; t++) begin
      peek(ADR_STATUS, d);
      if (accumIrq !== (t == 5) || d[1] !== (t == 5)) mism++;
      @(negedge clk);
    end
    chk(mism == 0, "R3 R5 flag rises after event", mism, 0);
    wrReg(ADR_ACCDIV, 1000);
    irqEnable = 1'b0;
    peek(ADR_STATUS, d);
    chk(accumIrq == 0, "R5 gated off", accumIrq, 0);
    chk(d[1] == 1, "R3 sticky while gated", d, 2);
    irqEnable = 1'b1;
    #1 chk(accumIrq == 1, "R5 gated on", accumIrq, 1);
    wrReg(ADR_CLEAR, 2);
    peek(ADR_STATUS, d);
    chk(d == 0 && accumIrq == 0, "R4 R5 clear acc", d, 0);

    // R4 selective clear
    wrReg(ADR_TICDIV, 3);
    waitCyc(5);
    wrReg(ADR_TICDIV, 5000);
    wrReg(ADR_CLEAR, 2);
    peek(ADR_STATUS, d); chk(d == 1, "R4 bit1 clear keeps bit0", d, 1);
    wrReg(ADR_CLEAR, 1);
    peek(ADR_STATUS, d); chk(d == 0, "R4 bit0 clear", d, 0);

    // R4 event beats clear
    wrReg(ADR_ACCDIV, 5);
    waitCyc(5);
    wrReg(ADR_CLEAR, 2);
    peek(ADR_STATUS, d); chk(d[1] == 1, "R4 event wins", d, 2);
    wrReg(ADR_ACCDIV, 1000);
    wrReg(ADR_CLEAR, 3);

    // R7 new-data bitmap
    dump(12'h005);
    dump(12'h800);
    rdNew(d); chk(d == 32'h805, "R7 bitmap", d, 32'h805);
    rdNew(d); chk(d == 0, "R7 read clears", d, 0);
    dump(12'h001);
    dumpIn = 12'h002;
    rdNew(d);
    dumpIn = '0;
    chk(d == 1, "R7 read before dump", d, 1);
    rdNew(d); chk(d == 2, "R7 dump beats clear", d, 2);
    mism = 0;
    for (int i = 0; i < NUM_CH; i++) begin
      dump(NUM_CH'(1) << i);
      rdNew(d);
      if (d != (32'd1 << i)) mism++;
    end
    chk(mism == 0, "R7 walking one", mism, 0);

    // R8 software reset
    wrReg(ADR_TICDIV, 3);
    wrReg(ADR_ACCDIV, 3);
    dump(12'h003);
    waitCyc(4);
    wrReg(ADR_SWRST, 1);
    @(negedge clk);
    mism = 0;
    for (int t = 0; t < 10; t++) begin
      peek(ADR_TICCNT, d); if (d != 3) mism++;
      peek(ADR_ACCCNT, d); if (d != 3) mism++;
      if (ticStrobe !== 1'b0) mism++;
      @(negedge clk);
    end
    chk(mism == 0, "R8 hold", mism, 0);
    peek(ADR_STATUS, d);  chk(d == 0, "R8 status cleared", d, 0);
    peek(ADR_NEWDATA, d); chk(d == 0, "R8 newdata cleared", d, 0);
    peek(ADR_SWRST, d);   chk(d == 1, "R8 readback", d, 1);
    wrReg(ADR_SWRST, 0);
    mism = 0;
    for (int t = 0; t < 8; t++) begin
      if (ticStrobe !== ((t % 4) == 3)) mism++;
      @(negedge clk);
    end
    chk(mism == 0, "R8 release phase", mism, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule